// File: doc/BRIEF.md
# Multi-Mode PWM Compare Channel

This block pairs a parameterised counter (16 bits by default) with one compare channel to produce a pulse-width-modulated waveform. The counter can run edge-aligned upward, edge-aligned downward, or center-aligned, rising from zero to the period value and falling back. The channel compares the count with a compare value and forms a reference waveform in one of two opposite senses. An optional inversion then yields the pin-level output. A sticky flag records compare matches. In center-aligned operation, a select code chooses whether the flag is set on the rising slope, the falling slope or both.

Period and compare values are written into holding registers. Each one can be set either to load into its working copy only at an update event, or to act at once. An update event happens whenever the counter turns at an end point. A software update request through the register port does the same job: it loads both working copies and restarts the count, so the first period after configuration is already correct.

Configuration goes through a plain write port. A write is accepted in the cycle it is presented, with no back-pressure. There is no streamed data path, so no valid/ready handshake is used.

Top module: `pwm_cmp_channel`

## Requirements
- R1: After reset, the count, reference, output and flag are all 0, the reported direction is upward (0), and every register is zero. Register addresses: 0 control, 1 period, 2 compare, 3 event. Control bits: [0] run, [1] count-down select, [3:2] alignment select, [4] period hold enable, [5] compare hold enable, [6] active-low output, [9:7] waveform mode.
- R2: With alignment 00, count-down 0 and run 1, the count rises by one per cycle. When it is at or above the working period it returns to 0 on the next cycle, and that step is an update event.
- R3: With alignment 00, count-down 1 and run 1, the count falls by one per cycle. When it is 0 it loads the working period on the next cycle, and that step is an update event.
- R4: With alignment 01, 10 or 11, the count runs 0 up to the period and back down to 0, with each end point an update event. Control bit [1] is ignored, and the direction output shows 1 while falling.
- R5: In mode 110 (sense A) with edge-aligned up-counting, the reference is 1 while count < compare. A compare above the period holds it at 1, and a compare of 0 holds it at 0.
- R6: In sense A with edge-aligned down-counting, the reference is 1 while count <= compare, so a compare above the period holds it at 1.
- R7: In sense A with center alignment, a compare of 0 holds the reference at 0, a compare at or above the period holds it at 1, and otherwise it is 1 while count < compare.
- R8: Mode 111 (sense B) gives the inverse of sense A. Any other mode code holds the reference at 0.
- R9: The output equals the reference when control bit [6] is 0, and its inverse when bit [6] is 1.
- R10: The flag is set by a cycle with run 1 and count equal to the working compare. In center alignment, code 01 counts only falling matches, code 10 only rising matches (the top end point counts as rising) and code 11 counts both.
- R11: The flag stays set until a write of 1 to event bit [1]. A match in the same cycle as that write wins over the clear.
- R12: With a hold enable set, the working period or compare takes the written value only at an update event or a software update. With the enable clear, the written value acts on the next cycle.
- R13: Writing 1 to event bit [0] is a software update. It loads both working copies, sets the count to 0 and sets the center direction upward.
- R14: With run 0 and no software update, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| ref_o | output | 1 | Reference waveform |
| pwm_o | output | 1 | Polarity-adjusted output |
| flag_o | output | 1 | Sticky compare flag |
| dir_down_o | output | 1 | 1 while the count is falling |

## Verification
The waveform is driven with a mid-range compare, a compare above the period and a compare of zero in each counting arrangement. This separates the strict and inclusive comparisons and exposes the saturation rules, including the missing 0% duty when counting down. Running the same settings under sense B and under active-low polarity shows that inversion and polarity act at separate points. All three center flag codes run over the same triangle waveform, so a flag set on the wrong slope appears as a mismatch on a clean flag. Holding and immediate loading are compared by writing the period and compare in the middle of a period.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CMP    = 2'd2;
  localparam logic [1:0] ADDR_EVT    = 2'd3;

  localparam logic [2:0] MODE_SENSE_A = 3'b110;
  localparam logic [2:0] MODE_SENSE_B = 3'b111;

  typedef enum logic [1:0] {
    ALIGN_EDGE      = 2'b00,
    ALIGN_FLAG_DN   = 2'b01,
    ALIGN_FLAG_UP   = 2'b10,
    ALIGN_FLAG_BOTH = 2'b11
  } align_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       act_low;
    logic       cmp_hold;
    logic       per_hold;
    align_e     align;
    logic       down;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             uev_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic [CNT_W-1:0] per_shadow_o,
  output logic             sw_upd_o,
  output logic             flag_clr_o
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_pre_q, cmp_pre_q;
  logic [CNT_W-1:0] per_sh_q, cmp_sh_q;
  logic             evt_wr;
  logic             load_sh;

  assign evt_wr     = wr_en && (wr_addr == ADDR_EVT);
  assign sw_upd_o   = evt_wr && wr_data[0];
  assign flag_clr_o = evt_wr && wr_data[1];
  assign load_sh    = sw_upd_o || uev_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      per_pre_q <= '0;
      cmp_pre_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL:   ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_PERIOD: per_pre_q <= wr_data;
        ADDR_CMP:    cmp_pre_q <= wr_data;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q <= '0;
      cmp_sh_q <= '0;
    end else if (load_sh) begin
      per_sh_q <= per_pre_q;
      cmp_sh_q <= cmp_pre_q;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign per_act_o    = ctrl_q.per_hold ? per_sh_q : per_pre_q;
  assign cmp_act_o    = ctrl_q.cmp_hold ? cmp_sh_q : cmp_pre_q;
  assign per_shadow_o = per_sh_q;

endmodule

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             down_i,
  input  align_e           align_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             sw_upd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             going_down_o,
  output logic             uev_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             center;
  logic             uev;

  assign center = (align_i != ALIGN_EDGE);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = center ? up_q : 1'b1;
    uev   = 1'b0;
    if (sw_upd_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (run_i) begin
      if (!center) begin
        if (!down_i) begin
          if (cnt_q >= per_i) begin
            cnt_d = '0;
            uev   = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_d = per_i;
            uev   = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end else if (up_q) begin
        if (cnt_q >= per_i) begin
          up_d  = 1'b0;
          cnt_d = (per_i == '0) ? '0 : per_i - ONE;
          uev   = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          up_d  = 1'b1;
          cnt_d = (per_i == '0) ? '0 : ONE;
          uev   = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o        = cnt_q;
  assign going_down_o = center ? ~up_q : down_i;
  assign uev_o        = uev;

endmodule

// File: rtl/pwm_cmp_compare.sv
module pwm_cmp_compare
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             going_down_i,
  input  ctrl_t            ctrl_i,
  input  logic             flag_clr_i,
  output logic             ref_o,
  output logic             pwm_o,
  output logic             flag_o
);

  logic base;
  logic refv;
  logic slope_ok;
  logic hit;
  logic flag_q;

  always_comb begin
    if (ctrl_i.align != ALIGN_EDGE) begin
      if (cmp_i == '0)         base = 1'b0;
      else if (cmp_i >= per_i) base = 1'b1;
      else                     base = (cnt_i < cmp_i);
    end else if (ctrl_i.down) begin
      base = (cnt_i <= cmp_i);
    end else begin
      base = (cnt_i < cmp_i);
    end
  end

  always_comb begin
    case (ctrl_i.mode)
      MODE_SENSE_A: refv = base;
      MODE_SENSE_B: refv = ~base;
      default:      refv = 1'b0;
    endcase
  end

  always_comb begin
    case (ctrl_i.align)
      ALIGN_FLAG_DN: slope_ok = going_down_i;
      ALIGN_FLAG_UP: slope_ok = ~going_down_i;
      default:       slope_ok = 1'b1;
    endcase
  end

  assign hit = ctrl_i.run && (cnt_i == cmp_i) && slope_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q & ~flag_clr_i) | hit;
  end

  assign ref_o  = refv;
  assign pwm_o  = refv ^ ctrl_i.act_low;
  assign flag_o = flag_q;

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_o,
  output logic             pwm_o,
  output logic             flag_o,
  output logic             dir_down_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] per_act, cmp_act, per_shadow;
  logic             sw_upd, flag_clr, upd_evt;

  pwm_cmp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .uev_i        (upd_evt),
    .ctrl_o       (ctrl),
    .per_act_o    (per_act),
    .cmp_act_o    (cmp_act),
    .per_shadow_o (per_shadow),
    .sw_upd_o     (sw_upd),
    .flag_clr_o   (flag_clr)
  );

  pwm_cmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ctrl.run),
    .down_i       (ctrl.down),
    .align_i      (ctrl.align),
    .per_i        (per_act),
    .sw_upd_i     (sw_upd),
    .cnt_o        (cnt_o),
    .going_down_o (dir_down_o),
    .uev_o        (upd_evt)
  );

  pwm_cmp_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_i        (cnt_o),
    .per_i        (per_act),
    .cmp_i        (cmp_act),
    .going_down_i (dir_down_o),
    .ctrl_i       (ctrl),
    .flag_clr_i   (flag_clr),
    .ref_o        (ref_o),
    .pwm_o        (pwm_o),
    .flag_o       (flag_o)
  );

endmodule

// File: rtl/pwm_cmp_channel_chk.sv
module pwm_cmp_channel_chk
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ref_o,
  input logic             flag_o,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic [CNT_W-1:0] per_shadow,
  input logic             upd_evt,
  input logic             sw_upd
);

  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == ADDR_EVT) && wr_data[1];

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_wr) |=> flag_o); // R11

  AST_SHADOW_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !sw_upd) |=> $stable(per_shadow)); // R12

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !sw_upd) |=> $stable(cnt_o)); // R14

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !sw_upd && ctrl.align == ALIGN_EDGE && !ctrl.down && cnt_o >= per_act)
      |=> (cnt_o == '0)); // R2

  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_SENSE_A && cmp_act == '0 && !(ctrl.align == ALIGN_EDGE && ctrl.down))
      |-> !ref_o); // R5

  AST_SW_UPDATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (cnt_o == '0)); // R13

endmodule

bind pwm_cmp_channel pwm_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .cnt_o      (cnt_o),
  .ref_o      (ref_o),
  .flag_o     (flag_o),
  .ctrl       (ctrl),
  .per_act    (per_act),
  .cmp_act    (cmp_act),
  .per_shadow (per_shadow),
  .upd_evt    (upd_evt),
  .sw_upd     (sw_upd)
);

// File: tb/pwm_cmp_channel_bench.sv
module pwm_cmp_channel_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic         ref_o, pwm_o, flag_o, dir_down_o;

  always #2.5 clk = ~clk;

  pwm_cmp_channel #(.CNT_W(W)) u_pwm_cmp_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .ref_o(ref_o), .pwm_o(pwm_o), .flag_o(flag_o), .dir_down_o(dir_down_o)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic         rf;
    logic         pw;
    logic         fl;
    logic         dn;
    string        tag;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  // Model state, built from the requirements
  logic         m_run, m_down, m_perh, m_cmph, m_low;
  logic [1:0]   m_align;
  logic [2:0]   m_mode;
  logic [W-1:0] m_per_pre, m_cmp_pre, m_per_sh, m_cmp_sh, m_cnt;
  logic         m_up, m_flag;

  function automatic logic [W-1:0] act_per();
    return m_perh ? m_per_sh : m_per_pre;
  endfunction
  function automatic logic [W-1:0] act_cmp();
    return m_cmph ? m_cmp_sh : m_cmp_pre;
  endfunction
  function automatic logic m_dn();
    return (m_align != 2'b00) ? ~m_up : m_down;
  endfunction
  function automatic logic m_ref();
    logic [W-1:0] p, c;
    logic b;
    p = act_per(); c = act_cmp();
    if (m_align != 2'b00) b = (c == 0) ? 1'b0 : (c >= p) ? 1'b1 : (m_cnt < c);
    else if (m_down)      b = (m_cnt <= c);
    else                  b = (m_cnt < c);
    if (m_mode == 3'b110) return b;
    if (m_mode == 3'b111) return ~b;
    return 1'b0;
  endfunction

  task automatic model_edge(input bit we, input logic [1:0] a, input logic [W-1:0] d);
    logic [W-1:0] p, c, n_cnt;
    logic ug, clr, uev, slope, hit, n_up, center;
    p = act_per(); c = act_cmp();
    ug  = we && a == 2'd3 && d[0];
    clr = we && a == 2'd3 && d[1];
    center = (m_align != 2'b00);
    case (m_align)
      2'b01:   slope = m_dn();
      2'b10:   slope = ~m_dn();
      default: slope = 1'b1;
    endcase
    hit = m_run && (m_cnt == c) && slope;
    n_cnt = m_cnt; n_up = center ? m_up : 1'b1; uev = 1'b0;
    if (ug) begin n_cnt = 0; n_up = 1'b1; end
    else if (m_run) begin
      if (!center && !m_down) begin
        if (m_cnt >= p) begin n_cnt = 0; uev = 1; end else n_cnt = m_cnt + 1;
      end else if (!center) begin
        if (m_cnt == 0) begin n_cnt = p; uev = 1; end else n_cnt = m_cnt - 1;
      end else if (m_up) begin
        if (m_cnt >= p) begin n_up = 0; n_cnt = (p == 0) ? 0 : p - 1; uev = 1; end
        else n_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin n_up = 1; n_cnt = (p == 0) ? 0 : 1; uev = 1; end
        else n_cnt = m_cnt - 1;
      end
    end
    m_flag = (m_flag & ~clr) | hit;
    if (ug || uev) begin m_per_sh = m_per_pre; m_cmp_sh = m_cmp_pre; end
    m_cnt = n_cnt; m_up = n_up;
    if (we) begin
      case (a)
        2'd0: begin
          m_run = d[0]; m_down = d[1]; m_align = d[3:2]; m_perh = d[4];
          m_cmph = d[5]; m_low = d[6]; m_mode = d[9:7];
        end
        2'd1: m_per_pre = d;
        2'd2: m_cmp_pre = d;
        default: ;
      endcase
    end
  endtask

  // Driver: one call per clock, pushes the expected post-edge state
  task automatic step(input bit we, input logic [1:0] a, input logic [W-1:0] d);
    exp_t e;
    wr_en = we; wr_addr = a; wr_data = d;
    model_edge(we, a, d);
    e.cnt = m_cnt; e.rf = m_ref(); e.pw = m_ref() ^ m_low; e.fl = m_flag; e.dn = m_dn();
    e.tag = cur_tag;
    sb.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    step(1'b1, a, d);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0);
  endtask

  function automatic logic [W-1:0] cfg(input logic run, input logic down, input logic [1:0] al,
                                       input logic ph, input logic ch, input logic low,
                                       input logic [2:0] mode);
    return {6'b0, mode, low, ch, ph, al, down, run};
  endfunction

  // Monitor: compares each produced cycle with the queued expectation
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (cnt_o !== e.cnt || ref_o !== e.rf || pwm_o !== e.pw || flag_o !== e.fl ||
            dir_down_o !== e.dn) begin
          fails++;
          $display("FAIL %s: cnt/ref/pwm/flag/dn actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
                   e.tag, cnt_o, ref_o, pwm_o, flag_o, dir_down_o,
                   e.cnt, e.rf, e.pw, e.fl, e.dn);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_run = 0; m_down = 0; m_perh = 0; m_cmph = 0; m_low = 0; m_align = 0; m_mode = 0;
    m_per_pre = 0; m_cmp_pre = 0; m_per_sh = 0; m_cmp_sh = 0; m_cnt = 0; m_up = 1; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    checks++;
    if (cnt_o !== 0 || ref_o !== 0 || pwm_o !== 0 || flag_o !== 0 || dir_down_o !== 0) begin
      fails++;
      $display("FAIL R1: cnt/ref/pwm/flag/dn actual %0d/%b/%b/%b/%b expected 0/0/0/0/0",
               cnt_o, ref_o, pwm_o, flag_o, dir_down_o);
    end

    // R2 R5 R10 R13: edge up, period 8, compare 4, held values
    cur_tag = "R2/R5/R10/R13";
    wr(2'd1, 16'd8); wr(2'd2, 16'd4);
    wr(2'd0, cfg(0, 0, 2'b00, 1, 1, 0, 3'b110));
    wr(2'd3, 16'd1);
    wr(2'd0, cfg(1, 0, 2'b00, 1, 1, 0, 3'b110));
    idle(20);
    cur_tag = "R11";
    wr(2'd3, 16'd2); idle(2);

    // R12 R5: compare above period, then zero, taken at update events
    cur_tag = "R5/R12";
    wr(2'd2, 16'd9); idle(14);
    wr(2'd2, 16'd0); idle(14);

    // R8 R9: sense B, active-low, then an unused mode code
    cur_tag = "R8/R9";
    wr(2'd2, 16'd3);
    wr(2'd0, cfg(1, 0, 2'b00, 1, 1, 1, 3'b111)); idle(20);
    cur_tag = "R8";
    wr(2'd0, cfg(1, 0, 2'b00, 1, 1, 0, 3'b010)); idle(6);

    // R3 R6: edge down
    cur_tag = "R3/R6";
    wr(2'd0, cfg(0, 1, 2'b00, 1, 1, 0, 3'b110));
    wr(2'd1, 16'd5); wr(2'd2, 16'd2); wr(2'd3, 16'd3);
    wr(2'd0, cfg(1, 1, 2'b00, 1, 1, 0, 3'b110)); idle(16);
    wr(2'd2, 16'd9); idle(14);

    // R4 R7 R10: center modes, each flag code, count-down bit set and ignored
    for (int al = 1; al < 4; al++) begin
      cur_tag = "R4/R7/R10";
      wr(2'd0, cfg(0, 1, al[1:0], 1, 1, 0, 3'b110));
      wr(2'd1, 16'd8); wr(2'd2, 16'd4); wr(2'd3, 16'd3);
      wr(2'd0, cfg(1, 1, al[1:0], 1, 1, 0, 3'b110)); idle(20);
      wr(2'd3, 16'd2); idle(10);
    end
    cur_tag = "R7";
    wr(2'd2, 16'd8); idle(20);
    wr(2'd2, 16'd0); idle(20);
    wr(2'd2, 16'd7); idle(20);

    // R12: immediate loading with hold disabled
    cur_tag = "R12";
    wr(2'd0, cfg(1, 0, 2'b00, 0, 0, 0, 3'b110));
    idle(3);
    wr(2'd1, 16'd3); idle(6);
    wr(2'd2, 16'd2); idle(6);

    // R14: stopped counter holds
    cur_tag = "R14";
    wr(2'd0, cfg(0, 0, 2'b00, 0, 0, 0, 3'b110)); idle(6);

    @(posedge clk); #3;
    finish_run();
  end

endmodule